// File: doc/BRIEF.md
# Conditional Execute and Flag-Write Control

This block sits between instruction decode and execute. For each decoded instruction it picks the condition code that governs it. Inside an if-then block, the condition comes from the block state tag. Outside a block, it comes from the instruction's own condition field. The block then tests that condition against the current N, Z, C and V flags and raises an execute-enable when the test passes.

It also decides whether the instruction may write the flags. Most 16-bit arithmetic and logical forms stop setting flags while an if-then block is active. The compare and test forms keep setting them.

Finally, it produces a strobe that tells the if-then tracker to commit its next state. The strobe fires for any valid instruction that ran inside a block without a fault, whether or not its condition passed, so the block always advances.

All three outputs are registered. They appear on the clock edge after the inputs are presented.

Top module: `cond_exec_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `exec_en`, `flag_we` and `it_commit` are 0.
- R2: When the low nibble `it_tag[3:0]` (the block mask) is nonzero, the condition tested is `it_tag[7:4]`. When the mask is zero, the condition tested is `in_cond`.
- R3: The condition is evaluated with `nzcv` = {N,Z,C,V} as follows: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear, 8 C set and Z clear, 9 C clear or Z set, 10 N equals V, 11 N differs from V, 12 Z clear and N equals V, 13 Z set or N differs from V.
- R4: Condition values 14 and 15 always pass.
- R5: Outputs are registered: every output reflects the inputs sampled at the previous rising clock edge. A cycle with `in_valid` low yields all outputs low.
- R6: For a narrow instruction with `in_hw[15:14]`=00 (the shift/add/subtract/move/compare group, opcode `in_hw[13:11]`), opcode 5 (compare immediate) requests a flag write always. The other seven opcodes request one only when the mask is zero.
- R7: For a narrow instruction with `in_hw[15:10]`=010000 (the register data-processing group, opcode `in_hw[9:6]`), opcodes 8 (test), 10 (compare) and 11 (compare negative) request a flag write always. All other opcodes request one only when the mask is zero.
- R8: Any other instruction (wide, or narrow outside those two groups) requests a flag write exactly when `in_sets_flags` is 1, whatever the mask.
- R9: `it_commit` is 1 exactly when the instruction was valid, the mask was nonzero and `in_fault` was 0. This holds whether the condition passed or failed.
- R10: `exec_en` is 1 only for a valid instruction whose condition passes. `flag_we` is 1 only when `exec_en` is 1 and a flag write was requested.
- R11: The if-then instruction itself (narrow 0xBFxy, y nonzero) and the no-operation (narrow 0xBF00) go through the same condition test as every other instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is present |
| in_narrow | input | 1 | Instruction is a 16-bit encoding |
| in_hw | input | 10 | Bits [15:6] of the 16-bit encoding |
| in_sets_flags | input | 1 | Flag-write request for forms outside the two narrow groups |
| in_cond | input | 4 | Instruction's own condition field |
| it_tag | input | 8 | If-then state tag: [7:4] condition, [3:0] mask |
| nzcv | input | 4 | Current flags {N,Z,C,V} |
| in_fault | input | 1 | Instruction completed with a fault |
| exec_en | output | 1 | Instruction executes |
| flag_we | output | 1 | Instruction may write flags |
| it_commit | output | 1 | Commit the next if-then state |

## Verification
The assertions assume that `in_fault` is meaningful only when `in_valid` is high. They also assume that `in_hw` and `it_tag` are stable for the whole cycle in which they are sampled. The stimulus drives every input on the falling edge and holds it through the next rising edge. It sweeps all 16 conditions against all 16 flag combinations, both inside and outside a block. It covers every opcode of both narrow groups with the mask zero and nonzero, and combines fault and condition failure with the mask nonzero. No stimulus raises `in_fault` alone on an idle cycle in a way any check depends on.

// File: rtl/cond_exec_ctrl.sv
module cond_exec_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_narrow,
  input  logic [15:6] in_hw,
  input  logic        in_sets_flags,
  input  logic [3:0]  in_cond,
  input  logic [7:0]  it_tag,
  input  logic [3:0]  nzcv,
  input  logic        in_fault,
  output logic        exec_en,
  output logic        flag_we,
  output logic        it_commit
);

  logic       in_block;
  logic [3:0] cond_sel;
  logic       fn, fz, fc, fv;
  logic       cond_pass;
  logic       grp_shadd, grp_dp;
  logic       keep_shadd, keep_dp;
  logic       wants_flags;

  assign in_block = |it_tag[3:0];
  assign cond_sel = in_block ? it_tag[7:4] : in_cond;
  assign {fn, fz, fc, fv} = nzcv;

  always_comb begin
    case (cond_sel)
      4'h0:    cond_pass = fz;
      4'h1:    cond_pass = !fz;
      4'h2:    cond_pass = fc;
      4'h3:    cond_pass = !fc;
      4'h4:    cond_pass = fn;
      4'h5:    cond_pass = !fn;
      4'h6:    cond_pass = fv;
      4'h7:    cond_pass = !fv;
      4'h8:    cond_pass = fc && !fz;
      4'h9:    cond_pass = !fc || fz;
      4'hA:    cond_pass = (fn == fv);
      4'hB:    cond_pass = (fn != fv);
      4'hC:    cond_pass = !fz && (fn == fv);
      4'hD:    cond_pass = fz || (fn != fv);
      default: cond_pass = 1'b1;
    endcase
  end

  assign grp_shadd  = in_narrow && (in_hw[15:14] == 2'b00);
  assign grp_dp     = in_narrow && (in_hw[15:10] == 6'b010000);
  assign keep_shadd = (in_hw[13:11] == 3'd5);
  assign keep_dp    = (in_hw[9:6] == 4'h8) || (in_hw[9:6] == 4'hA) ||
                      (in_hw[9:6] == 4'hB);

  always_comb begin
    if (grp_shadd)   wants_flags = keep_shadd || !in_block;
    else if (grp_dp) wants_flags = keep_dp || !in_block;
    else             wants_flags = in_sets_flags;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_en   <= 1'b0;
      flag_we   <= 1'b0;
      it_commit <= 1'b0;
    end else begin
      exec_en   <= in_valid && cond_pass;
      flag_we   <= in_valid && cond_pass && wants_flags;
      it_commit <= in_valid && in_block && !in_fault;
    end
  end

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!exec_en && !flag_we && !it_commit));

  assert_flag_needs_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> exec_en);

  assert_always_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && it_tag[3:0] == 4'h0 && in_cond[3:1] == 3'b111) |=> exec_en);

  assert_commit_in_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && it_tag[3:0] != 4'h0 && !in_fault) |=> it_commit);

  assert_no_commit_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (it_tag[3:0] == 4'h0 || in_fault) |=> !it_commit);

  assert_shadd_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_narrow && in_hw[15:14] == 2'b00 && in_hw[13:11] != 3'd5 &&
     it_tag[3:0] != 4'h0) |=> !flag_we);

  assert_dp_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_narrow && in_hw[15:10] == 6'b010000 && in_hw[9:8] != 2'b10 &&
     it_tag[3:0] != 4'h0) |=> !flag_we);

endmodule

// File: tb/tb_cond_exec_ctrl.sv
`timescale 1ns/1ps
module tb_cond_exec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_narrow = 1'b0;
  logic [15:6] in_hw = '0;
  logic        in_sets_flags = 1'b0;
  logic [3:0]  in_cond = '0;
  logic [7:0]  it_tag = '0;
  logic [3:0]  nzcv = '0;
  logic        in_fault = 1'b0;
  logic        exec_en, flag_we, it_commit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cond_exec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_narrow(in_narrow),
    .in_hw(in_hw), .in_sets_flags(in_sets_flags), .in_cond(in_cond),
    .it_tag(it_tag), .nzcv(nzcv), .in_fault(in_fault),
    .exec_en(exec_en), .flag_we(flag_we), .it_commit(it_commit));

  function automatic bit model_pass(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v, base;
    {n, z, cy, v} = f;
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    return (c[3:1] == 3'd7) ? 1'b1 : (base ^ c[0]);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic nar, input logic [15:6] hw,
                      input logic sf, input logic [3:0] c, input logic [7:0] tag,
                      input logic [3:0] f, input logic flt);
    in_valid = v; in_narrow = nar; in_hw = hw; in_sets_flags = sf;
    in_cond = c; it_tag = tag; nzcv = f; in_fault = flt;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 exec in reset", exec_en, 1'b0);
    chk("R1 flag in reset", flag_we, 1'b0);
    chk("R1 commit in reset", it_commit, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 exec after reset", exec_en, 1'b0);
    chk("R1 commit after reset", it_commit, 1'b0);

    // R3 R4: outside a block, own condition field, all flags
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        step(1, 0, '0, 1, c[3:0], 8'h00, f[3:0], 0);
        chk("R3 own cond exec", exec_en, model_pass(c[3:0], f[3:0]));
        chk("R10 own cond flag", flag_we, model_pass(c[3:0], f[3:0]));
        chk("R9 no commit outside", it_commit, 1'b0);
      end

    // R2: inside a block the tag condition wins over in_cond
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        step(1, 0, '0, 0, ~c[3:0], {c[3:0], 4'b1000}, f[3:0], 0);
        chk("R2 tag cond exec", exec_en, model_pass(c[3:0], f[3:0]));
        chk("R9 commit on pass or fail", it_commit, 1'b1);
        chk("R8 wide no flag request", flag_we, 1'b0);
      end

    // R4 explicit always codes
    step(1, 0, '0, 0, 4'hE, 8'h00, 4'h0, 0);
    chk("R4 cond E", exec_en, 1'b1);
    step(1, 0, '0, 0, 4'hF, 8'h00, 4'hF, 0);
    chk("R4 cond F", exec_en, 1'b1);

    // R6: shift/add group
    for (int op = 0; op < 8; op++)
      for (int m = 0; m < 2; m++) begin
        step(1, 1, {2'b00, op[2:0], 5'b10101}, 0, 4'hE,
             m ? 8'hE4 : 8'h00, 4'h0, 0);
        chk("R6 shadd flag", flag_we, (op == 5) || (m == 0));
        chk("R6 shadd exec", exec_en, 1'b1);
      end

    // R7: register data-processing group
    for (int op = 0; op < 16; op++)
      for (int m = 0; m < 2; m++) begin
        step(1, 1, {6'b010000, op[3:0]}, 0, 4'hE,
             m ? 8'hE1 : 8'h00, 4'h0, 0);
        chk("R7 dp flag", flag_we,
            (op == 8) || (op == 10) || (op == 11) || (m == 0));
      end

    // R8: other narrow form ignores mask, follows in_sets_flags
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 2; m++) begin
        step(1, 1, 10'b0101_1100_00, s[0], 4'hE, m ? 8'hE8 : 8'h00, 4'h0, 0);
        chk("R8 other flag", flag_we, s[0]);
      end

    // R10: failing condition in block, compare kept form -> no exec, no flag
    step(1, 1, {2'b00, 3'd5, 5'b0}, 0, 4'hE, 8'h08, 4'b0000, 0);
    chk("R10 fail exec", exec_en, 1'b0);
    chk("R10 fail flag", flag_we, 1'b0);
    chk("R9 commit on fail", it_commit, 1'b1);

    // R9: fault suppresses commit
    step(1, 0, '0, 1, 4'hE, 8'hE8, 4'h0, 1);
    chk("R9 fault no commit", it_commit, 1'b0);
    chk("R9 fault exec", exec_en, 1'b1);

    // R11: IT and NOP encodings are conditioned
    step(1, 1, 10'b1011_1111_00, 0, 4'hE, 8'h18, 4'b0100, 0);
    chk("R11 nop cond fail", exec_en, 1'b0);
    step(1, 1, 10'b1011_1111_01, 0, 4'hE, 8'h08, 4'b0100, 0);
    chk("R11 it cond pass", exec_en, 1'b1);
    step(1, 1, 10'b1011_1111_01, 0, 4'h1, 8'h00, 4'b0100, 0);
    chk("R11 it own cond fail", exec_en, 1'b0);

    // R5: idle cycle
    step(0, 1, '0, 1, 4'hE, 8'hE8, 4'h0, 0);
    chk("R5 idle exec", exec_en, 1'b0);
    chk("R5 idle flag", flag_we, 1'b0);
    chk("R5 idle commit", it_commit, 1'b0);

    // R1: reset in mid-stream
    in_valid = 1; in_cond = 4'hE; it_tag = 8'hE8; rst_n = 0;
    @(negedge clk);
    chk("R1 re-reset exec", exec_en, 1'b0);
    chk("R1 re-reset commit", it_commit, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule